// File: doc/BRIEF.md
# I2C Master Segment Sequencer

This block drives an I2C bus as a master by working through a short queue of segment commands. Each command describes one stretch of bus traffic: whether to open it with a START (or repeated START), whether it transmits or receives, how many bytes it moves, whether a STOP closes it, whether the final received byte is answered with NAK, and whether the bus stays claimed (SCL held low) while the engine waits for a following command. Bit-level timing lives in a separate bus-bit engine. This block hands that engine one operation at a time (START, write byte, read byte, STOP) over a valid/done handshake.

Transmit bytes come out of 32-bit words in a small data queue. Received bytes are gathered into 32-bit words and placed in a read queue. Software loads commands and data first and then sets the run control. The block reports normal completion and three error kinds through sticky flags, and each flag is cleared by a one in a clear mask. A typical register read is a one-byte transmit segment that carries the register index and keeps the bus held, followed by a receive segment with repeated START, NAK-on-last and STOP.

Top module: `i2cq_engine`

## Requirements
- R1: No bus operation is issued until `run_set` has been pulsed, even when commands and data are already queued.
- R2: Command word fields are count [7:0], transmit direction [8] (1 = transmit), START [9], STOP [10], NAK-on-last [11], hold [12] and master [13]. Within a segment the order is START (if flagged), then the bytes, then STOP (if flagged). `bus_op` encodes START=0, WRITE=1, READ=2 and STOP=3, and it stays stable while `bus_op_valid` waits for `bus_op_done`.
- R3: Transmit bytes are taken from each data word starting with bits 7:0. A segment that ends partway through a word discards that word's unused upper bytes, and the next segment starts on a fresh word.
- R4: In a receive segment every byte is answered with ACK (`bus_ack_out`=0), except that the last byte gets NAK (`bus_ack_out`=1) when NAK-on-last is set.
- R5: Received bytes are packed with the first byte in bits 7:0. A segment that ends partway through a word pushes that word with zeroed upper bytes. `rdq_empty` is 1 exactly when no word is waiting.
- R6: If a segment carries the hold flag and no further command is queued, the engine waits with no bus operation and no completion. A command pushed later continues on the bus, with a START only if that command asks for one.
- R7: When the command queue drains normally and the last segment has no hold flag, status bit 0 (done) is set.
- R8: When a written byte is not acknowledged, status bit 1 is set and a STOP is issued if the bus is owned. All queued commands and transmit words are discarded, and done is not set.
- R9: `bus_arb_lost` or `bus_early_term` reported with an operation's done sets status bit 3 or bit 2 respectively, and ends the run without a STOP.
- R10: A receive command with count 0, or a command with the master bit clear, issues no bus operation and sets status bit 2.
- R11: A transmit command with count 0 issues only its START (if flagged) and its STOP (if flagged).
- R12: Each status bit is cleared by a 1 in the same position of `stat_clr`; a set in the same cycle wins.
- R13: When the transmit queue runs empty in the middle of a segment, the engine issues nothing until a new word arrives and then resumes with that word's low byte.
- R14: The command queue and the transmit queue each hold 4 entries. `cmd_full` and `txd_full` report a full queue, and a push into a full queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_push | input | 1 | Push `cmd_word` into the command queue |
| cmd_word | input | 14 | Segment command word |
| cmd_full | output | 1 | Command queue full |
| txd_push | input | 1 | Push `txd_word` into the transmit queue |
| txd_word | input | 32 | Transmit data word |
| txd_full | output | 1 | Transmit queue full |
| run_set | input | 1 | Start executing the queued commands |
| rdq_pop | input | 1 | Remove the head word of the read queue |
| rdq_word | output | 32 | Head word of the read queue |
| rdq_empty | output | 1 | Read queue empty |
| stat | output | 4 | Flags: 0 done, 1 no-ACK, 2 early/illegal, 3 arbitration lost |
| stat_clr | input | 4 | Write-one-to-clear mask for `stat` |
| bus_op_valid | output | 1 | Operation request to the bus-bit engine |
| bus_op | output | 2 | Operation code |
| bus_tx_byte | output | 8 | Byte for a WRITE operation |
| bus_ack_out | output | 1 | Acknowledge bit to send after a READ (1 = NAK) |
| bus_op_done | input | 1 | Bus-bit engine finished the operation |
| bus_rx_byte | input | 8 | Byte received by a READ |
| bus_rx_nack | input | 1 | Slave did not acknowledge a WRITE |
| bus_arb_lost | input | 1 | Arbitration lost during the operation |
| bus_early_term | input | 1 | Bus terminated early during the operation |

## Verification
The transaction shapes tried are a plain multi-word write, a held write chained into a read with repeated START and NAK-on-last, a held write followed by a read without START, a zero-count write, a write that starves the data queue in the middle, and queue-full pushes. Each shape separates a different slip: a wrong byte lane or a missed partial-word discard shows up as a wrong write byte in the next segment, and a wrong ACK choice shows up on the final read. Error runs inject a no-ACK, an arbitration loss and an early termination at chosen operations, and then rerun a fresh transfer. That rerun tells a proper flush apart from stale commands or data being replayed.

// File: rtl/i2cq_pkg.sv
// Shared definitions for the I2C segment sequencer.
package i2cq_pkg;
    // Operation handed to the bus-bit engine.
    typedef enum logic [1:0] {
        BOP_START = 2'd0,
        BOP_WRITE = 2'd1,
        BOP_READ  = 2'd2,
        BOP_STOP  = 2'd3
    } bus_op_e;

    // Status flag positions.
    localparam int FLAG_DONE  = 0;
    localparam int FLAG_NACK  = 1;
    localparam int FLAG_EARLY = 2;
    localparam int FLAG_ARB   = 3;
    localparam int FLAG_N     = 4;

    // Command field offsets above the count field.
    localparam int CF_TX    = 0;
    localparam int CF_START = 1;
    localparam int CF_STOP  = 2;
    localparam int CF_NAK   = 3;
    localparam int CF_HOLD  = 4;
    localparam int CF_MST   = 5;
    localparam int CF_N     = 6;
endpackage

// File: rtl/i2cq_fifo.sv
// Small synchronous FIFO with flush.
// Assumes: a push while full and a pop while empty are ignored; dout shows the head entry.
module i2cq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/i2cq_status.sv
// Sticky status flags with a write-one-to-clear mask.
// Assumes: a set and a clear of the same bit in one cycle leave the bit set.
module i2cq_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky bit: set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cq_seq.sv
// Segment sequencer: decodes queued commands, issues bus operations one at a
// time, unpacks transmit words, packs received bytes and raises status pulses.
// Assumes: the bus-bit engine holds done for one cycle per accepted request and
// reports error inputs together with done.
module i2cq_seq
    import i2cq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DW    = 32,
    localparam int CMD_W = CNT_W + CF_N,
    localparam int BPW   = DW / 8,
    localparam int BI_W  = (BPW > 1) ? $clog2(BPW) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_set,
    input  logic [CMD_W-1:0] cmd_head,
    input  logic             cmd_empty,
    output logic             cmd_pop,
    output logic             cmd_flush,
    input  logic [DW-1:0]    txd_head,
    input  logic             txd_empty,
    output logic             txd_pop,
    output logic             txd_flush,
    input  logic             rdq_full,
    output logic             rdq_push,
    output logic [DW-1:0]    rdq_data,
    output logic             bus_op_valid,
    output bus_op_e          bus_op,
    output logic [7:0]       bus_tx_byte,
    output logic             bus_ack_out,
    input  logic             bus_op_done,
    input  logic [7:0]       bus_rx_byte,
    input  logic             bus_rx_nack,
    input  logic             bus_arb_lost,
    input  logic             bus_early_term,
    output logic [FLAG_N-1:0] flag_set
);
    typedef enum logic [3:0] {
        ST_IDLE, ST_LOAD, ST_START, ST_DATA, ST_END,
        ST_STOP, ST_NEXT, ST_ABORT, ST_ASTOP
    } state_e;

    state_e           state;
    logic             run_q, owned, abort_stop;
    logic             cur_tx, cur_start, cur_stop, cur_nak, cur_hold;
    logic [CNT_W-1:0] remain;
    logic [BI_W-1:0]  bidx;
    logic [DW-1:0]    pack;

    logic             fire, bus_err, nack_err, illegal, last_byte, word_full, data_ready;
    logic [DW-1:0]    pack_nx;

    assign illegal    = !cmd_head[CNT_W + CF_MST] ||
                        (!cmd_head[CNT_W + CF_TX] && (cmd_head[CNT_W-1:0] == '0));
    assign data_ready = cur_tx ? !txd_empty : !rdq_full;
    assign last_byte  = (remain == CNT_W'(1));
    assign word_full  = (bidx == BI_W'(BPW - 1));
    assign pack_nx    = pack | (DW'(bus_rx_byte) << (8 * bidx));

    // Request to the bus-bit engine.
    always_comb begin
        bus_op_valid = 1'b0;
        bus_op       = BOP_START;
        case (state)
            ST_START: bus_op_valid = 1'b1;
            ST_STOP, ST_ASTOP: begin
                bus_op_valid = 1'b1;
                bus_op       = BOP_STOP;
            end
            ST_DATA: begin
                bus_op_valid = (remain != '0) && data_ready;
                bus_op       = cur_tx ? BOP_WRITE : BOP_READ;
            end
            default: ;
        endcase
    end

    assign bus_tx_byte = txd_head[8 * bidx +: 8];
    assign bus_ack_out = !cur_tx && cur_nak && last_byte;

    assign fire     = bus_op_valid && bus_op_done;
    assign bus_err  = fire && (bus_arb_lost || bus_early_term);
    assign nack_err = fire && (state == ST_DATA) && cur_tx && bus_rx_nack && !bus_err;

    // Queue controls.
    assign cmd_pop   = (state == ST_LOAD);
    assign cmd_flush = (state == ST_ABORT);
    assign txd_flush = (state == ST_ABORT);
    assign txd_pop   = ((state == ST_DATA) && fire && cur_tx && word_full) ||
                       ((state == ST_END) && cur_tx && (bidx != '0));
    assign rdq_push  = (state == ST_DATA) && fire && !cur_tx && !bus_err &&
                       (word_full || last_byte);
    assign rdq_data  = pack_nx;

    // Status pulses.
    always_comb begin
        flag_set             = '0;
        flag_set[FLAG_DONE]  = (state == ST_NEXT) && cmd_empty && !cur_hold;
        flag_set[FLAG_NACK]  = nack_err;
        flag_set[FLAG_EARLY] = (fire && bus_early_term) || ((state == ST_LOAD) && illegal);
        flag_set[FLAG_ARB]   = fire && bus_arb_lost;
    end

    // Segment state machine and byte bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            run_q      <= 1'b0;
            owned      <= 1'b0;
            abort_stop <= 1'b0;
            cur_tx     <= 1'b0;
            cur_start  <= 1'b0;
            cur_stop   <= 1'b0;
            cur_nak    <= 1'b0;
            cur_hold   <= 1'b0;
            remain     <= '0;
            bidx       <= '0;
            pack       <= '0;
        end else begin
            if (run_set) run_q <= 1'b1;
            case (state)
                ST_IDLE: if (run_q && !cmd_empty) state <= ST_LOAD;
                ST_LOAD: begin
                    cur_tx    <= cmd_head[CNT_W + CF_TX];
                    cur_start <= cmd_head[CNT_W + CF_START];
                    cur_stop  <= cmd_head[CNT_W + CF_STOP];
                    cur_nak   <= cmd_head[CNT_W + CF_NAK];
                    cur_hold  <= cmd_head[CNT_W + CF_HOLD];
                    remain    <= cmd_head[CNT_W-1:0];
                    bidx      <= '0;
                    pack      <= '0;
                    if (illegal) begin
                        abort_stop <= owned;
                        state      <= ST_ABORT;
                    end else if (cmd_head[CNT_W + CF_START]) begin
                        state <= ST_START;
                    end else begin
                        state <= ST_DATA;
                    end
                end
                ST_START: if (fire) begin
                    if (bus_err) begin
                        owned      <= 1'b0;
                        abort_stop <= 1'b0;
                        state      <= ST_ABORT;
                    end else begin
                        owned <= 1'b1;
                        state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (remain == '0) begin
                        state <= ST_END;
                    end else if (fire) begin
                        if (bus_err) begin
                            owned      <= 1'b0;
                            abort_stop <= 1'b0;
                            state      <= ST_ABORT;
                        end else if (nack_err) begin
                            abort_stop <= owned;
                            state      <= ST_ABORT;
                        end else begin
                            remain <= remain - CNT_W'(1);
                            bidx   <= bidx + BI_W'(1);
                            if (!cur_tx) pack <= rdq_push ? '0 : pack_nx;
                        end
                    end
                end
                ST_END: state <= cur_stop ? ST_STOP : ST_NEXT;
                ST_STOP: if (fire) begin
                    owned <= 1'b0;
                    if (bus_err) begin
                        abort_stop <= 1'b0;
                        state      <= ST_ABORT;
                    end else begin
                        state <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    if (!cmd_empty) begin
                        state <= ST_LOAD;
                    end else if (!cur_hold) begin
                        run_q <= 1'b0;
                        state <= ST_IDLE;
                    end
                end
                ST_ABORT: begin
                    run_q <= 1'b0;
                    pack  <= '0;
                    state <= abort_stop ? ST_ASTOP : ST_IDLE;
                end
                ST_ASTOP: if (fire) begin
                    owned <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cq_engine.sv
// Top of the I2C segment sequencer: command, transmit and read queues around
// the sequencer, plus the sticky status flags.
// Assumes: a separate bus-bit engine executes one operation per valid/done handshake.
module i2cq_engine
    import i2cq_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int DW         = 32,
    parameter int CMDQ_DEPTH = 4,
    parameter int TXQ_DEPTH  = 4,
    parameter int RDQ_DEPTH  = 4,
    localparam int CMD_W     = CNT_W + CF_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_push,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              cmd_full,
    input  logic              txd_push,
    input  logic [DW-1:0]     txd_word,
    output logic              txd_full,
    input  logic              run_set,
    input  logic              rdq_pop,
    output logic [DW-1:0]     rdq_word,
    output logic              rdq_empty,
    output logic [FLAG_N-1:0] stat,
    input  logic [FLAG_N-1:0] stat_clr,
    output logic              bus_op_valid,
    output logic [1:0]        bus_op,
    output logic [7:0]        bus_tx_byte,
    output logic              bus_ack_out,
    input  logic              bus_op_done,
    input  logic [7:0]        bus_rx_byte,
    input  logic              bus_rx_nack,
    input  logic              bus_arb_lost,
    input  logic              bus_early_term
);
    logic [CMD_W-1:0]  cmd_head;
    logic              cmd_empty, cmd_pop, cmd_flush;
    logic [DW-1:0]     txd_head;
    logic              txd_empty, txd_pop, txd_flush;
    logic              rdq_full, rdq_push;
    logic [DW-1:0]     rdq_data;
    logic [FLAG_N-1:0] flag_set;
    bus_op_e           seq_op;

    assign bus_op = seq_op;

    i2cq_fifo #(.W(CMD_W), .DEPTH(CMDQ_DEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(cmd_word), .pop(cmd_pop),
        .flush(cmd_flush), .dout(cmd_head), .full(cmd_full), .empty(cmd_empty)
    );

    i2cq_fifo #(.W(DW), .DEPTH(TXQ_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(txd_push), .din(txd_word), .pop(txd_pop),
        .flush(txd_flush), .dout(txd_head), .full(txd_full), .empty(txd_empty)
    );

    i2cq_fifo #(.W(DW), .DEPTH(RDQ_DEPTH)) u_rdq (
        .clk(clk), .rst_n(rst_n), .push(rdq_push), .din(rdq_data), .pop(rdq_pop),
        .flush(1'b0), .dout(rdq_word), .full(rdq_full), .empty(rdq_empty)
    );

    i2cq_seq #(.CNT_W(CNT_W), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .run_set(run_set),
        .cmd_head(cmd_head), .cmd_empty(cmd_empty), .cmd_pop(cmd_pop), .cmd_flush(cmd_flush),
        .txd_head(txd_head), .txd_empty(txd_empty), .txd_pop(txd_pop), .txd_flush(txd_flush),
        .rdq_full(rdq_full), .rdq_push(rdq_push), .rdq_data(rdq_data),
        .bus_op_valid(bus_op_valid), .bus_op(seq_op), .bus_tx_byte(bus_tx_byte),
        .bus_ack_out(bus_ack_out), .bus_op_done(bus_op_done), .bus_rx_byte(bus_rx_byte),
        .bus_rx_nack(bus_rx_nack), .bus_arb_lost(bus_arb_lost),
        .bus_early_term(bus_early_term), .flag_set(flag_set)
    );

    i2cq_status #(.N(FLAG_N)) u_stat (
        .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(stat_clr), .flags(stat)
    );
endmodule

// File: rtl/i2cq_engine_chk.sv
// Property checker for i2cq_engine, attached by bind.
// Assumes: observes ports and the queue/status handshakes between submodules.
module i2cq_engine_chk
    import i2cq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_op_valid,
    input logic [1:0]        bus_op,
    input logic              bus_op_done,
    input logic              bus_rx_nack,
    input logic              bus_arb_lost,
    input logic [FLAG_N-1:0] stat,
    input logic [FLAG_N-1:0] stat_clr,
    input logic [FLAG_N-1:0] flag_set,
    input logic              rdq_push,
    input logic              rdq_full,
    input logic              txd_empty
);
    assert_op_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op_valid && !bus_op_done) |=> (bus_op_valid && $stable(bus_op)));

    assert_write_has_data_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op_valid && bus_op == BOP_WRITE) |-> !txd_empty);

    assert_rdq_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rdq_push |-> !rdq_full);

    assert_nack_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[FLAG_NACK]) |->
        $past(bus_op_valid && bus_op_done && bus_rx_nack && bus_op == BOP_WRITE));

    assert_arb_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[FLAG_ARB]) |-> $past(bus_op_valid && bus_op_done && bus_arb_lost));

    for (genvar i = 0; i < FLAG_N; i++) begin : g_clr
        assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_clr[i] && !flag_set[i]) |=> !stat[i]);
    end
endmodule

bind i2cq_engine i2cq_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_op_valid(bus_op_valid), .bus_op(bus_op),
    .bus_op_done(bus_op_done), .bus_rx_nack(bus_rx_nack), .bus_arb_lost(bus_arb_lost),
    .stat(stat), .stat_clr(stat_clr), .flag_set(flag_set), .rdq_push(rdq_push),
    .rdq_full(rdq_full), .txd_empty(txd_empty)
);

// File: tb/tb_i2cq_engine.sv
// Scoreboard bench: tasks queue the expected bus operations and read words,
// a bus-bit model pops and compares each operation as the design issues it.
module tb_i2cq_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_push = 1'b0;
    logic [13:0] cmd_word = '0;
    logic        cmd_full;
    logic        txd_push = 1'b0;
    logic [31:0] txd_word = '0;
    logic        txd_full;
    logic        run_set = 1'b0;
    logic        rdq_pop = 1'b0;
    logic [31:0] rdq_word;
    logic        rdq_empty;
    logic [3:0]  stat;
    logic [3:0]  stat_clr = '0;
    logic        bus_op_valid;
    logic [1:0]  bus_op;
    logic [7:0]  bus_tx_byte;
    logic        bus_ack_out;
    logic        bus_op_done = 1'b0;
    logic [7:0]  bus_rx_byte = '0;
    logic        bus_rx_nack = 1'b0;
    logic        bus_arb_lost = 1'b0;
    logic        bus_early_term = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [9:0] val;
        string      tag;
    } exp_t;
    exp_t        exp_q[$];
    logic [7:0]  rx_q[$];
    int          op_seen = 0;
    int          inj_at = -1;
    int          inj_kind = 0;

    always #2 clk = ~clk;

    i2cq_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_word(cmd_word),
        .cmd_full(cmd_full), .txd_push(txd_push), .txd_word(txd_word),
        .txd_full(txd_full), .run_set(run_set), .rdq_pop(rdq_pop),
        .rdq_word(rdq_word), .rdq_empty(rdq_empty), .stat(stat), .stat_clr(stat_clr),
        .bus_op_valid(bus_op_valid), .bus_op(bus_op), .bus_tx_byte(bus_tx_byte),
        .bus_ack_out(bus_ack_out), .bus_op_done(bus_op_done), .bus_rx_byte(bus_rx_byte),
        .bus_rx_nack(bus_rx_nack), .bus_arb_lost(bus_arb_lost),
        .bus_early_term(bus_early_term)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Driver helpers.
    task automatic push_cmd(input bit st, input bit sp, input bit tx, input bit nk,
                            input bit hd, input bit ms, input int cnt);
        @(negedge clk);
        cmd_word = {ms, hd, nk, sp, st, tx, 8'(cnt)};
        cmd_push = 1'b1;
        @(negedge clk);
        cmd_push = 1'b0;
    endtask

    task automatic push_txd(input logic [31:0] w);
        @(negedge clk);
        txd_word = w;
        txd_push = 1'b1;
        @(negedge clk);
        txd_push = 1'b0;
    endtask

    task automatic pulse_run();
        @(negedge clk);
        run_set = 1'b1;
        @(negedge clk);
        run_set = 1'b0;
    endtask

    task automatic clear_stat(input logic [3:0] m);
        @(negedge clk);
        stat_clr = m;
        @(negedge clk);
        stat_clr = '0;
    endtask

    task automatic exp_op(input logic [1:0] op, input logic [7:0] b, input string tag);
        exp_t e;
        e.val = {op, b};
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_end();
        int n = 0;
        while (stat == 4'h0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic pop_rd(input logic [31:0] exp, input string tag);
        @(negedge clk);
        check(!rdq_empty, {tag, " rdq_empty"}, 32'(rdq_empty), 32'h0);
        check(rdq_word == exp, tag, rdq_word, exp);
        rdq_pop = 1'b1;
        @(negedge clk);
        rdq_pop = 1'b0;
    endtask

    // Bus-bit model and monitor: compares every issued operation with the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bus_op_valid) begin
                logic [9:0] act;
                case (bus_op)
                    2'd1:    act = {bus_op, bus_tx_byte};
                    2'd2:    act = {bus_op, 7'h0, bus_ack_out};
                    default: act = {bus_op, 8'h0};
                endcase
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected bus operation", 32'(act), 32'h3ff);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(act == e.val, e.tag, 32'(act), 32'(e.val));
                end
                repeat (2) @(negedge clk);
                bus_rx_nack    = (inj_kind == 1) && (op_seen == inj_at);
                bus_arb_lost   = (inj_kind == 2) && (op_seen == inj_at);
                bus_early_term = (inj_kind == 3) && (op_seen == inj_at);
                bus_rx_byte    = (bus_op == 2'd2 && rx_q.size() > 0) ? rx_q.pop_front() : 8'hEE;
                bus_op_done    = 1'b1;
                op_seen++;
                @(negedge clk);
                bus_op_done    = 1'b0;
                bus_rx_nack    = 1'b0;
                bus_arb_lost   = 1'b0;
                bus_early_term = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        check(stat == 4'h0, "reset stat", 32'(stat), 32'h0);
        check(rdq_empty == 1'b1, "R5 reset rdq_empty", 32'(rdq_empty), 32'h1);
        check(!cmd_full && !txd_full, "R14 reset full flags", 32'({cmd_full, txd_full}), 32'h0);
        check(bus_op_valid == 1'b0, "R1 reset no op", 32'(bus_op_valid), 32'h0);

        // R14: transmit queue full, fifth word ignored.
        push_txd(32'h03020100);
        push_txd(32'h07060504);
        push_txd(32'h0B0A0908);
        push_txd(32'h0F0E0D0C);
        check(txd_full == 1'b1, "R14 txd_full", 32'(txd_full), 32'h1);
        push_txd(32'hDEADBEEF);
        push_cmd(1, 1, 1, 0, 0, 1, 16);
        exp_op(2'd0, 8'h00, "R2 start before 16-byte write");
        for (int i = 0; i < 16; i++) exp_op(2'd1, 8'(i), "R3 R14 write byte from full queue");
        exp_op(2'd3, 8'h00, "R2 stop after 16-byte write");
        pulse_run();
        wait_end();
        check(stat == 4'b0001, "R7 done after 16-byte write", 32'(stat), 32'h1);
        check(exp_q.size() == 0, "R2 all ops seen", 32'(exp_q.size()), 32'h0);
        clear_stat(4'b0001);
        check(stat == 4'h0, "R12 done cleared", 32'(stat), 32'h0);

        // R1 R3: gating and partial-word discard across segments.
        push_cmd(1, 1, 1, 0, 0, 1, 6);
        push_cmd(1, 1, 1, 0, 0, 1, 1);
        push_txd(32'h44332211);
        push_txd(32'hAABB6655);
        push_txd(32'h000000A7);
        exp_op(2'd0, 8'h00, "R2 start seg1");
        exp_op(2'd1, 8'h11, "R3 byte0");
        exp_op(2'd1, 8'h22, "R3 byte1");
        exp_op(2'd1, 8'h33, "R3 byte2");
        exp_op(2'd1, 8'h44, "R3 byte3");
        exp_op(2'd1, 8'h55, "R3 byte4");
        exp_op(2'd1, 8'h66, "R3 byte5");
        exp_op(2'd3, 8'h00, "R2 stop seg1");
        exp_op(2'd0, 8'h00, "R2 start seg2");
        exp_op(2'd1, 8'hA7, "R3 fresh word after partial");
        exp_op(2'd3, 8'h00, "R2 stop seg2");
        repeat (30) @(negedge clk);
        check(bus_op_valid == 1'b0, "R1 no op before run", 32'(bus_op_valid), 32'h0);
        check(exp_q.size() == 11, "R1 nothing issued before run", 32'(exp_q.size()), 32'd11);
        pulse_run();
        wait_end();
        check(stat == 4'b0001, "R7 done after two segments", 32'(stat), 32'h1);
        clear_stat(4'b0001);

        // R6 R4 R5: held write, later read with repeated start and NAK-on-last.
        push_cmd(1, 0, 1, 0, 1, 1, 1);
        push_txd(32'h000000A1);
        exp_op(2'd0, 8'h00, "R2 start address seg");
        exp_op(2'd1, 8'hA1, "R3 address byte");
        pulse_run();
        repeat (100) @(negedge clk);
        check(stat == 4'h0, "R6 no done while held", 32'(stat), 32'h0);
        check(bus_op_valid == 1'b0, "R6 idle while held", 32'(bus_op_valid), 32'h0);
        check(exp_q.size() == 0, "R6 held ops seen", 32'(exp_q.size()), 32'h0);
        for (int i = 0; i < 6; i++) rx_q.push_back(8'h10 + 8'(i));
        exp_op(2'd0, 8'h00, "R6 repeated start");
        for (int i = 0; i < 5; i++) exp_op(2'd2, 8'h00, "R4 ack on earlier byte");
        exp_op(2'd2, 8'h01, "R4 nak on last byte");
        exp_op(2'd3, 8'h00, "R2 stop after read");
        push_cmd(1, 1, 0, 1, 0, 1, 6);
        wait_end();
        check(stat == 4'b0001, "R7 done after read", 32'(stat), 32'h1);
        pop_rd(32'h13121110, "R5 full read word");
        pop_rd(32'h00001514, "R5 partial read word");
        @(negedge clk);
        check(rdq_empty == 1'b1, "R5 rdq drained", 32'(rdq_empty), 32'h1);
        clear_stat(4'b0001);

        // R6 R4: held write continued by a read without START, no NAK-on-last.
        push_cmd(1, 0, 1, 0, 1, 1, 1);
        push_cmd(0, 1, 0, 0, 0, 1, 2);
        push_txd(32'h0000005A);
        rx_q.push_back(8'hAA);
        rx_q.push_back(8'hBB);
        exp_op(2'd0, 8'h00, "R2 start");
        exp_op(2'd1, 8'h5A, "R3 index byte");
        exp_op(2'd2, 8'h00, "R6 read without start, ack");
        exp_op(2'd2, 8'h00, "R4 ack on last without nak flag");
        exp_op(2'd3, 8'h00, "R2 stop");
        pulse_run();
        wait_end();
        check(stat == 4'b0001, "R7 done", 32'(stat), 32'h1);
        pop_rd(32'h0000BBAA, "R5 two-byte word");
        clear_stat(4'b0001);

        // R11: zero-count transmit.
        push_cmd(1, 1, 1, 0, 0, 1, 0);
        exp_op(2'd0, 8'h00, "R11 start only");
        exp_op(2'd3, 8'h00, "R11 stop only");
        pulse_run();
        wait_end();
        check(stat == 4'b0001, "R11 done", 32'(stat), 32'h1);
        clear_stat(4'b0001);

        // R13: transmit queue starves mid-segment.
        push_cmd(1, 1, 1, 0, 0, 1, 5);
        push_txd(32'h04030201);
        exp_op(2'd0, 8'h00, "R2 start");
        for (int i = 1; i <= 4; i++) exp_op(2'd1, 8'(i), "R13 bytes before stall");
        exp_op(2'd1, 8'hC5, "R13 byte after refill");
        exp_op(2'd3, 8'h00, "R2 stop");
        pulse_run();
        repeat (100) @(negedge clk);
        check(bus_op_valid == 1'b0, "R13 stalled", 32'(bus_op_valid), 32'h0);
        check(exp_q.size() == 2, "R13 ops left while stalled", 32'(exp_q.size()), 32'd2);
        push_txd(32'h000000C5);
        wait_end();
        check(stat == 4'b0001, "R13 done after refill", 32'(stat), 32'h1);
        clear_stat(4'b0001);

        // R8: no-ACK on second byte, then flushed state proven by a fresh run.
        push_cmd(1, 1, 1, 0, 0, 1, 3);
        push_cmd(1, 1, 1, 0, 0, 1, 1);
        push_txd(32'h00030201);
        push_txd(32'h00000099);
        inj_kind = 1;
        inj_at = op_seen + 2;
        exp_op(2'd0, 8'h00, "R2 start");
        exp_op(2'd1, 8'h01, "R3 byte0");
        exp_op(2'd1, 8'h02, "R8 nacked byte");
        exp_op(2'd3, 8'h00, "R8 stop after nack");
        pulse_run();
        wait_end();
        inj_kind = 0;
        check(stat == 4'b0010, "R8 nack flag only", 32'(stat), 32'h2);
        check(exp_q.size() == 0, "R8 no ops after stop", 32'(exp_q.size()), 32'h0);
        clear_stat(4'b0010);
        check(stat == 4'h0, "R12 nack cleared", 32'(stat), 32'h0);
        push_cmd(1, 1, 1, 0, 0, 1, 1);
        push_txd(32'h00000077);
        exp_op(2'd0, 8'h00, "R8 fresh start after flush");
        exp_op(2'd1, 8'h77, "R8 queues flushed");
        exp_op(2'd3, 8'h00, "R8 fresh stop");
        pulse_run();
        wait_end();
        check(stat == 4'b0001, "R8 fresh run done", 32'(stat), 32'h1);
        clear_stat(4'b0001);

        // R9: arbitration loss on first byte.
        push_cmd(1, 1, 1, 0, 0, 1, 2);
        push_txd(32'h0000CDAB);
        inj_kind = 2;
        inj_at = op_seen + 1;
        exp_op(2'd0, 8'h00, "R2 start");
        exp_op(2'd1, 8'hAB, "R9 lost byte");
        pulse_run();
        wait_end();
        inj_kind = 0;
        check(stat == 4'b1000, "R9 arb flag", 32'(stat), 32'h8);
        check(exp_q.size() == 0 && !bus_op_valid, "R9 no stop after arb",
              32'(exp_q.size()), 32'h0);
        clear_stat(4'b1000);

        // R9: early termination on START.
        push_cmd(1, 1, 1, 0, 0, 1, 1);
        push_txd(32'h00000011);
        inj_kind = 3;
        inj_at = op_seen;
        exp_op(2'd0, 8'h00, "R9 start terminated");
        pulse_run();
        wait_end();
        inj_kind = 0;
        check(stat == 4'b0100, "R9 early flag", 32'(stat), 32'h4);
        clear_stat(4'b0100);

        // R10: illegal commands.
        push_cmd(1, 1, 0, 0, 0, 1, 0);
        pulse_run();
        wait_end();
        check(stat == 4'b0100, "R10 zero-count read", 32'(stat), 32'h4);
        clear_stat(4'b0100);
        push_cmd(1, 1, 1, 0, 0, 0, 1);
        pulse_run();
        wait_end();
        check(stat == 4'b0100, "R10 master bit clear", 32'(stat), 32'h4);
        clear_stat(4'b0100);

        // R14: command queue full, fifth push ignored.
        for (int i = 0; i < 4; i++) push_cmd(1, 0, 1, 0, 0, 1, 0);
        check(cmd_full == 1'b1, "R14 cmd_full", 32'(cmd_full), 32'h1);
        push_cmd(1, 1, 1, 0, 0, 1, 0);
        for (int i = 0; i < 4; i++) exp_op(2'd0, 8'h00, "R14 start from queued cmd");
        pulse_run();
        wait_end();
        check(stat == 4'b0001, "R14 done", 32'(stat), 32'h1);
        check(exp_q.size() == 0, "R14 fifth command dropped", 32'(exp_q.size()), 32'h0);
        clear_stat(4'b0001);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule